// File: doc/BRIEF.md
# Fastlock Timeout Controller

This block runs a short fast-acquisition window for a PLL after each frequency change. A frequency-change strobe loads a down-counter with a programmable timeout. While the counter is non-zero, the block presents the fast-acquisition charge-pump gain code and the two fast-acquisition loop-filter resistor codes in place of the normal ones. It also pulls an open-drain style pad low. Outside the window the normal codes are presented and the pad is released to high impedance.

A strobe is accepted only when three conditions hold: the enable is set, the timeout is non-zero, and the fast gain code is strictly larger than the normal gain code. When the normal gain is already at the top, there is no larger current to switch in, so the strobe is refused. A strobe that arrives inside a running window restarts the window at full length. All code outputs and the pad controls are registered and change on one shared clock edge.

Top module: `fastlock_ctrl`

## Requirements
- R1: While rst_ni is low, active_o, pad_oe_o, cp_gain_o, res_a_o and res_b_o are all 0, and pad_do_o is 0.
- R2: An accepted strobe, sampled high at clock edge k, makes active_o high from edge k through edge k+T-1, and low from edge k+T. T is the value of timeout_i sampled at edge k, so the window lasts exactly T cycles.
- R3: cp_gain_o, res_a_o and res_b_o are registered. Each edge loads the fast inputs when the window is active after that edge, and the normal inputs otherwise.
- R4: pad_oe_o equals active_o on every cycle, and pad_do_o is always 0. A value of 1 on pad_oe_o drives the pad low; 0 releases it.
- R5: An accepted strobe during a running window reloads the counter, so the window ends exactly T cycles after the latest strobe.
- R6: With en_i low a strobe is ignored. Clearing en_i during a window ends it at the next edge, and that edge restores the normal codes.
- R7: A strobe with timeout_i equal to 0 does not start a window.
- R8: A strobe with cp_gain_fast_i less than or equal to cp_gain_norm_i (unsigned compare) is ignored.
- R9: active_o, pad_oe_o and all three code outputs switch on the same clock edge at the start and at the end of a window.
- R10: A change of timeout_i during a running window does not change that window's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Fast-acquisition enable |
| freq_chg_i | input | 1 | Frequency-change strobe, one cycle |
| timeout_i | input | TMO_W | Window length in cycles |
| cp_gain_norm_i | input | CPG_W | Normal charge-pump gain code |
| cp_gain_fast_i | input | CPG_W | Fast charge-pump gain code |
| res_a_norm_i | input | RES_W | Normal code, filter resistor A |
| res_a_fast_i | input | RES_W | Fast code, filter resistor A |
| res_b_norm_i | input | RES_W | Normal code, filter resistor B |
| res_b_fast_i | input | RES_W | Fast code, filter resistor B |
| cp_gain_o | output | CPG_W | Selected charge-pump gain code |
| res_a_o | output | RES_W | Selected resistor A code |
| res_b_o | output | RES_W | Selected resistor B code |
| pad_oe_o | output | 1 | Pad output enable (1 pulls low) |
| pad_do_o | output | 1 | Pad output data, constant 0 |
| active_o | output | 1 | Window active status |

## Verification
The assertions check on every cycle that the pad enable tracks the status bit and that the pad data stays low. They also check that each code register takes the fast or the normal value according to the prior cycle's selection, that the counter reloads, counts down and clears on disable, and that refused strobes (zero timeout, gain not larger) leave an idle block idle. Only the bench scenarios can show whole-window effects: the exact window length, the restart to full length after a late strobe, and that a timeout change in mid-window has no effect. They also show the ordering of the reset state, the first normal codes and the simultaneous switching of every output at both window edges.

// File: rtl/fl_pkg.sv
package fl_pkg;
  typedef enum logic {
    FL_NORMAL = 1'b0,
    FL_FAST   = 1'b1
  } fl_mode_e;

  localparam int unsigned FL_TMO_W_DEF = 16;
  localparam int unsigned FL_CPG_W_DEF = 5;
  localparam int unsigned FL_RES_W_DEF = 4;
endpackage

// File: rtl/fl_timer.sv
module fl_timer
  import fl_pkg::*;
#(
  parameter int unsigned TMO_W = FL_TMO_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             req_i,
  input  logic             gain_ok_i,
  input  logic [TMO_W-1:0] timeout_i,
  output fl_mode_e         mode_nxt_o,
  output logic             active_o
);
  localparam logic [TMO_W-1:0] CNT_ZERO = '0;
  localparam logic [TMO_W-1:0] CNT_ONE  = {{(TMO_W-1){1'b0}}, 1'b1};

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             fire;
  logic             running;

  assign running = (cnt_q != CNT_ZERO);
  assign fire    = req_i && en_i && gain_ok_i && (timeout_i != CNT_ZERO);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)        cnt_d = CNT_ZERO;
    else if (fire)    cnt_d = timeout_i;
    else if (running) cnt_d = cnt_q - CNT_ONE;
  end

  assign mode_nxt_o = (cnt_d != CNT_ZERO) ? FL_FAST : FL_NORMAL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_ZERO;
    else         cnt_q <= cnt_d;
  end

  assign active_o = running;

  // R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && en_i && gain_ok_i && timeout_i != CNT_ZERO) |=> cnt_q == $past(timeout_i));

  // R2
  countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && en_i && !req_i) |=> cnt_q == $past(cnt_q) - CNT_ONE);

  // R6
  disable_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !active_o);

  // R7
  zero_tmo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && timeout_i == CNT_ZERO) |=> !active_o);
endmodule

// File: rtl/fl_code_sel.sv
module fl_code_sel
  import fl_pkg::*;
#(
  parameter int unsigned W = FL_RES_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  fl_mode_e     mode_nxt_i,
  input  logic [W-1:0] norm_i,
  input  logic [W-1:0] fast_i,
  output logic [W-1:0] code_o
);
  logic [W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     code_q <= '0;
    else if (mode_nxt_i == FL_FAST)  code_q <= fast_i;
    else                             code_q <= norm_i;
  end

  assign code_o = code_q;

  // R3
  fast_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_nxt_i == FL_FAST) |=> code_o == $past(fast_i));

  // R3
  norm_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_nxt_i == FL_NORMAL) |=> code_o == $past(norm_i));
endmodule

// File: rtl/fl_pad_drv.sv
module fl_pad_drv
  import fl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  fl_mode_e mode_nxt_i,
  output logic     pad_oe_o,
  output logic     pad_do_o
);
  logic oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= (mode_nxt_i == FL_FAST);
  end

  assign pad_oe_o = oe_q;
  assign pad_do_o = 1'b0;
endmodule

// File: rtl/fastlock_ctrl.sv
module fastlock_ctrl
  import fl_pkg::*;
#(
  parameter int unsigned TMO_W = FL_TMO_W_DEF,
  parameter int unsigned CPG_W = FL_CPG_W_DEF,
  parameter int unsigned RES_W = FL_RES_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             freq_chg_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic [CPG_W-1:0] cp_gain_norm_i,
  input  logic [CPG_W-1:0] cp_gain_fast_i,
  input  logic [RES_W-1:0] res_a_norm_i,
  input  logic [RES_W-1:0] res_a_fast_i,
  input  logic [RES_W-1:0] res_b_norm_i,
  input  logic [RES_W-1:0] res_b_fast_i,
  output logic [CPG_W-1:0] cp_gain_o,
  output logic [RES_W-1:0] res_a_o,
  output logic [RES_W-1:0] res_b_o,
  output logic             pad_oe_o,
  output logic             pad_do_o,
  output logic             active_o
);
  localparam int unsigned N_RES = 2;

  fl_mode_e         mode_nxt;
  logic             gain_ok;
  logic [RES_W-1:0] res_norm [N_RES];
  logic [RES_W-1:0] res_fast [N_RES];
  logic [RES_W-1:0] res_sel  [N_RES];

  // fast gain must exceed normal gain, else nothing larger to switch in
  assign gain_ok = (cp_gain_fast_i > cp_gain_norm_i);

  fl_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .req_i      (freq_chg_i),
    .gain_ok_i  (gain_ok),
    .timeout_i  (timeout_i),
    .mode_nxt_o (mode_nxt),
    .active_o   (active_o)
  );

  fl_code_sel #(.W(CPG_W)) u_cpg_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_nxt_i (mode_nxt),
    .norm_i     (cp_gain_norm_i),
    .fast_i     (cp_gain_fast_i),
    .code_o     (cp_gain_o)
  );

  assign res_norm[0] = res_a_norm_i;
  assign res_fast[0] = res_a_fast_i;
  assign res_norm[1] = res_b_norm_i;
  assign res_fast[1] = res_b_fast_i;

  for (genvar g = 0; g < N_RES; g++) begin : g_res
    fl_code_sel #(.W(RES_W)) u_res_sel (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_nxt_i (mode_nxt),
      .norm_i     (res_norm[g]),
      .fast_i     (res_fast[g]),
      .code_o     (res_sel[g])
    );
  end

  assign res_a_o = res_sel[0];
  assign res_b_o = res_sel[1];

  fl_pad_drv u_pad (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_nxt_i (mode_nxt),
    .pad_oe_o   (pad_oe_o),
    .pad_do_o   (pad_do_o)
  );

  // R4
  pad_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o == active_o);

  // R4
  pad_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_do_o == 1'b0);

  // R8
  gain_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && (cp_gain_fast_i <= cp_gain_norm_i)) |=> !active_o);
endmodule

// File: tb/sim_fastlock_ctrl.sv
module sim_fastlock_ctrl;
  localparam int TMO_W = 16;
  localparam int CPG_W = 5;
  localparam int RES_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic             fchg = 1'b0;
  logic [TMO_W-1:0] tmo = '0;
  logic [CPG_W-1:0] cpg_n = 5'd3, cpg_f = 5'd12;
  logic [RES_W-1:0] ra_n = 4'd2, ra_f = 4'd9, rb_n = 4'd5, rb_f = 4'd14;
  logic [CPG_W-1:0] cpg_o;
  logic [RES_W-1:0] ra_o, rb_o;
  logic             oe_o, do_o, act_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fastlock_ctrl #(.TMO_W(TMO_W), .CPG_W(CPG_W), .RES_W(RES_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .freq_chg_i(fchg), .timeout_i(tmo),
    .cp_gain_norm_i(cpg_n), .cp_gain_fast_i(cpg_f),
    .res_a_norm_i(ra_n), .res_a_fast_i(ra_f), .res_b_norm_i(rb_n), .res_b_fast_i(rb_f),
    .cp_gain_o(cpg_o), .res_a_o(ra_o), .res_b_o(rb_o),
    .pad_oe_o(oe_o), .pad_do_o(do_o), .active_o(act_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) fchg = 1'b1;
    @(negedge clk) fchg = 1'b0;
  endtask

  task automatic measure(output int len);
    len = 0;
    while (act_o && len < 500) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic chk_normal(string req);
    chk({req, " cpg"}, cpg_o, cpg_n);
    chk({req, " ra"}, ra_o, ra_n);
    chk({req, " rb"}, rb_o, rb_n);
    chk({req, " oe"}, oe_o, 0);
    chk({req, " act"}, act_o, 0);
  endtask

  task automatic t_reset();
    #5;
    chk("R1 act", act_o, 0);
    chk("R1 oe", oe_o, 0);
    chk("R1 cpg", cpg_o, 0);
    chk("R1 ra", ra_o, 0);
    chk("R1 rb", rb_o, 0);
    chk("R1 do", do_o, 0);
    @(negedge clk) rst_n = 1'b1;
    en = 1'b1;
    @(negedge clk);
    chk_normal("R3 idle");
  endtask

  task automatic t_basic();
    int len;
    tmo = 16'd5;
    strobe();
    // R9: every output flips together at window start
    chk("R9 start cpg", cpg_o, cpg_f);
    chk("R9 start ra", ra_o, ra_f);
    chk("R9 start rb", rb_o, rb_f);
    chk("R4 oe", oe_o, 1);
    chk("R4 do", do_o, 0);
    measure(len);
    chk("R2 len5", len, 5);
    chk_normal("R9 end");
  endtask

  task automatic t_one();
    int len;
    tmo = 16'd1;
    strobe();
    measure(len);
    chk("R2 len1", len, 1);
  endtask

  task automatic t_retrig();
    int len;
    tmo = 16'd6;
    strobe();
    @(negedge clk);
    @(negedge clk);
    strobe();
    measure(len);
    chk("R5 restart len", len, 6);
  endtask

  task automatic t_disable();
    tmo = 16'd4;
    en = 1'b0;
    strobe();
    chk("R6 ignored", act_o, 0);
    @(negedge clk);
    chk("R6 ignored oe", oe_o, 0);
    en = 1'b1;
    tmo = 16'd8;
    strobe();
    chk("R6 started", act_o, 1);
    en = 1'b0;
    @(negedge clk);
    chk_normal("R6 abort");
    en = 1'b1;
  endtask

  task automatic t_zero();
    tmo = 16'd0;
    strobe();
    chk_normal("R7 zero");
    @(negedge clk);
    chk("R7 zero later", act_o, 0);
  endtask

  task automatic t_gain();
    tmo = 16'd5;
    cpg_f = cpg_n;
    strobe();
    chk_normal("R8 equal");
    cpg_f = 5'd1;
    strobe();
    chk_normal("R8 lower");
    cpg_f = 5'd12;
  endtask

  task automatic t_tmo_change();
    int len;
    tmo = 16'd4;
    strobe();
    tmo = 16'd10;
    measure(len);
    chk("R10 len", len, 4);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_one();
    t_retrig();
    t_disable();
    t_zero();
    t_gain();
    t_tmo_change();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule